// File: doc/BRIEF.md
# Self-Testable ECC-Protected SRAM

This block wraps a single-port word memory so that every 32-bit word is stored with 7 check bits of a single-error-correcting, double-error-detecting code. A write stores the data together with its freshly computed check bits. A read fetches the stored codeword and passes it through a bit-flip stage. The decoder then corrects one flipped bit, or flags two flipped bits as uncorrectable.

The bit-flip stage holds a small set of channels. Each channel has its own enable, target word address, data flip mask and check flip mask. It corrupts only the copy of the word on its way out of the array, so stored contents stay intact. An error reporter watches the decoder. When reporting is enabled it sets sticky flags, records the address of the first failing read of each kind, and drives level interrupts through separate enables. Software can therefore corrupt a chosen word, read it back, and confirm that the protection logic notices, before it turns on interrupts for normal operation.

Configuration goes through a simple register port that always accepts. Register reads are combinational, and writes take effect at the clock edge.

Top module: `ecc_sram_inj`

## Requirements
- R1: A read request (mem_req=1, mem_we=0) at a clock edge produces mem_rvalid=1 with mem_rdata, mem_ce and mem_ue valid during the following cycle. A write request produces no mem_rvalid.
- R2: When exactly one of the 39 bits of a codeword (32 data bits or 7 check bits) is flipped, the originally written data is returned with mem_ce=1 and mem_ue=0.
- R3: When exactly two bits of a codeword are flipped, mem_ue=1 and mem_ce=0, and mem_rdata is the uncorrected word, which is the written data XOR the applied data flip mask.
- R4: A channel flips bits only when its enable (channel register +0, bit 0) is 1 and its target (channel register +1) equals the read address. Otherwise the written data comes back with mem_ce=0 and mem_ue=0.
- R5: Injection never changes the stored word. Once the channel is disabled, a re-read returns clean data.
- R6: Status register 0x01 holds sticky flags, with bit 0 for a corrected event and bit 1 for an uncorrectable event. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: Register 0x02 (corrected) and register 0x03 (uncorrectable) hold the address of the first failing read. Each loads only while its flag is clear.
- R8: Control register 0x00 bit 0 enables corrected-event reporting and bit 1 enables uncorrectable-event reporting. With an enable at 0, events of that kind leave the status unchanged, but data is still corrected.
- R9: irq_ce equals status bit 0 AND control bit 2. irq_ue equals status bit 1 AND control bit 3.
- R10: After reset, every register reads 0 and both interrupts are 0.
- R11: Channel register +2 is the data flip mask and +3 bits 6:0 are the check flip mask. Channel c occupies registers 4+4c to 7+4c. When several enabled channels match the same address, their masks combine by XOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | ADDR_W | Word address |
| mem_wdata | input | 32 | Write data |
| mem_rvalid | output | 1 | Read data valid |
| mem_rdata | output | 32 | Read data (corrected, or raw when uncorrectable) |
| mem_ce | output | 1 | A single-bit error was corrected |
| mem_ue | output | 1 | Uncorrectable error response |
| reg_valid | input | 1 | Register access valid |
| reg_ready | output | 1 | Register port ready (always 1) |
| reg_write | input | 1 | 1 = register write |
| reg_addr | input | REG_AW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_ce | output | 1 | Corrected-error interrupt |
| irq_ue | output | 1 | Uncorrectable-error interrupt |

## Verification
The correction path is exercised with single flips at the lowest, highest and a middle data bit, at the lowest check bit and at the overall-parity check bit. These cases separate faults in data-position mapping from faults in the check-bit and parity handling. Double flips use two data bits, a data bit paired with a check bit, two check bits, and the two extreme data bits. These cases confirm that any even pair is reported as uncorrectable and returned raw rather than miscorrected. Unflipped words, non-matching addresses and mutually cancelling channel masks show that the flip stage stays transparent unless it is actually aimed at the read.

// File: rtl/ecc_inj_pkg.sv
// Shared constants and code functions for the ECC-protected memory.
// Assumes a 32-bit data word with a Hamming code over positions 1..38,
// parity bits at power-of-two positions, plus one overall parity bit.
package ecc_inj_pkg;

    localparam int DATA_W  = 32;
    localparam int CHK_W   = 7;
    localparam int HAM_W   = CHK_W - 1;          // Hamming syndrome width
    localparam int CODE_W  = DATA_W + CHK_W;
    localparam int POS_MAX = DATA_W + HAM_W;     // highest Hamming position

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
    } codeword_t;

    // Hamming position held by data bit idx (skips powers of two).
    function automatic int data_pos(input int idx);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p <= POS_MAX; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Check bits for a data word: Hamming bits, then overall parity on top.
    function automatic logic [CHK_W-1:0] ecc_gen(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        int pos;
        c = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pos = data_pos(i);
            for (int b = 0; b < HAM_W; b++) begin
                if (pos[b]) c[b] = c[b] ^ d[i];
            end
        end
        c[CHK_W-1] = ^{d, c[HAM_W-1:0]};
        return c;
    endfunction

endpackage

// File: rtl/ecc_sram_array.sv
// Single-port word memory with a registered read port.
// Stores whole codewords; one access per cycle; the read result, its
// address and a valid strobe appear the cycle after the request.
module ecc_sram_array #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wword,
    output logic [WORD_W-1:0] rword,
    output logic [ADDR_W-1:0] raddr,
    output logic              rvalid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    // Array write port.
    always_ff @(posedge clk) begin
        if (req && we) mem_q[addr] <= wword;
    end

    // Registered read data, address and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rword  <= '0;
            raddr  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= req && !we;
            if (req && !we) begin
                rword <= mem_q[addr];
                raddr <= addr;
            end
        end
    end
endmodule

// File: rtl/ecc_inj_stage.sv
// Bit-flip stage on the read path between the array and the decoder.
// Each enabled channel aimed at the read address XORs its masks into the
// word; matching channels combine by XOR. Purely combinational.
module ecc_inj_stage
    import ecc_inj_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NUM_CH = 2
) (
    input  logic [NUM_CH-1:0]             ch_en,
    input  logic [NUM_CH-1:0][ADDR_W-1:0] ch_addr,
    input  logic [NUM_CH-1:0][DATA_W-1:0] ch_dmask,
    input  logic [NUM_CH-1:0][CHK_W-1:0]  ch_cmask,
    input  logic [ADDR_W-1:0]             raddr,
    input  codeword_t                     word_in,
    output codeword_t                     word_out,
    output logic                          hit
);
    logic [NUM_CH-1:0]             ch_hit;
    logic [NUM_CH-1:0][DATA_W-1:0] dflip;
    logic [NUM_CH-1:0][CHK_W-1:0]  cflip;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Per-channel match and gated masks.
        always_comb begin
            ch_hit[c] = ch_en[c] && (ch_addr[c] == raddr);
            dflip[c]  = ch_hit[c] ? ch_dmask[c] : '0;
            cflip[c]  = ch_hit[c] ? ch_cmask[c] : '0;
        end
    end

    // Combine all channel masks and apply them to the word.
    always_comb begin
        logic [DATA_W-1:0] dx;
        logic [CHK_W-1:0]  cx;
        dx = '0;
        cx = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            dx = dx ^ dflip[c];
            cx = cx ^ cflip[c];
        end
        word_out.data = word_in.data ^ dx;
        word_out.chk  = word_in.chk ^ cx;
        hit           = |ch_hit;
    end
endmodule

// File: rtl/ecc_secded_dec.sv
// Combinational decoder: recomputes syndrome and overall parity,
// corrects one flipped bit, flags even-weight or out-of-range errors
// as uncorrectable and then passes the raw data unchanged.
module ecc_secded_dec
    import ecc_inj_pkg::*;
(
    input  codeword_t         word_in,
    output logic [DATA_W-1:0] data_out,
    output logic              ce,
    output logic              ue
);
    logic [CHK_W-1:0]  recalc;
    logic [HAM_W-1:0]  syn;
    logic              par_err;
    logic              in_range;
    logic [DATA_W-1:0] fix;

    // Syndrome and overall-parity evaluation.
    always_comb begin
        recalc   = ecc_gen(word_in.data);
        syn      = recalc[HAM_W-1:0] ^ word_in.chk[HAM_W-1:0];
        par_err  = ^{word_in.data, word_in.chk};
        in_range = syn <= HAM_W'(POS_MAX);
        ce       = par_err && in_range;
        ue       = (!par_err && (syn != '0)) || (par_err && !in_range);
    end

    // Locate the data bit to flip back for a correctable error.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            fix[i] = ce && (syn == HAM_W'(data_pos(i)));
        end
        data_out = word_in.data ^ fix;
    end
endmodule

// File: rtl/ecc_err_report.sv
// Error reporter: sticky corrected / uncorrectable flags with
// write-one-to-clear, first-fault address capture per kind. Events are
// counted only when the matching reporting enable is set.
module ecc_err_report #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic              evt_ce,
    input  logic              evt_ue,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              rep_ce_en,
    input  logic              rep_ue_en,
    input  logic              clr_ce,
    input  logic              clr_ue,
    output logic              ce_flag,
    output logic              ue_flag,
    output logic [ADDR_W-1:0] ce_addr,
    output logic [ADDR_W-1:0] ue_addr
);
    logic hit_ce;
    logic hit_ue;

    // Qualify decoder events with reporting enables.
    always_comb begin
        hit_ce = evt_valid && evt_ce && rep_ce_en;
        hit_ue = evt_valid && evt_ue && rep_ue_en;
    end

    // Corrected-event flag and first-fault address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_flag <= 1'b0;
            ce_addr <= '0;
        end else begin
            if (hit_ce) ce_flag <= 1'b1;
            else if (clr_ce) ce_flag <= 1'b0;
            if (hit_ce && (!ce_flag || clr_ce)) ce_addr <= evt_addr;
        end
    end

    // Uncorrectable-event flag and first-fault address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ue_flag <= 1'b0;
            ue_addr <= '0;
        end else begin
            if (hit_ue) ue_flag <= 1'b1;
            else if (clr_ue) ue_flag <= 1'b0;
            if (hit_ue && (!ue_flag || clr_ue)) ue_addr <= evt_addr;
        end
    end
endmodule

// File: rtl/ecc_sram_inj.sv
// ECC-protected memory with a runtime bit-flip injection path and an
// error reporter. Register map (word index): 0 control, 1 status (W1C),
// 2 corrected address, 3 uncorrectable address, 4+4c.. channel c
// (enable, target, data mask, check mask). Register port always ready.
module ecc_sram_inj
    import ecc_inj_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NUM_CH = 2,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_wdata,
    output logic              mem_rvalid,
    output logic [31:0]       mem_rdata,
    output logic              mem_ce,
    output logic              mem_ue,
    input  logic              reg_valid,
    output logic              reg_ready,
    input  logic              reg_write,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_ce,
    output logic              irq_ue
);
    localparam int SEL_W = REG_AW - 2;

    logic [3:0]                    ctrl_q;
    logic [NUM_CH-1:0]             ch_en;
    logic [NUM_CH-1:0][ADDR_W-1:0] ch_addr;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_dmask;
    logic [NUM_CH-1:0][CHK_W-1:0]  ch_cmask;
    logic                          reg_wr;
    logic                          clr_ce;
    logic                          clr_ue;
    logic                          ce_flag;
    logic                          ue_flag;
    logic [ADDR_W-1:0]             ce_addr;
    logic [ADDR_W-1:0]             ue_addr;
    codeword_t                     wr_word;
    codeword_t                     arr_word;
    codeword_t                     inj_word;
    logic [ADDR_W-1:0]             arr_addr;
    logic                          inj_hit;

    // Register write strobe and status clear pulses.
    always_comb begin
        reg_ready = 1'b1;
        reg_wr    = reg_valid && reg_write;
        clr_ce    = reg_wr && (reg_addr == REG_AW'(1)) && reg_wdata[0];
        clr_ue    = reg_wr && (reg_addr == REG_AW'(1)) && reg_wdata[1];
    end

    // Control register: reporting enables [1:0], interrupt enables [3:2].
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (reg_wr && (reg_addr == '0)) ctrl_q <= reg_wdata[3:0];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
        // Channel c configuration registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_en[c]    <= 1'b0;
                ch_addr[c]  <= '0;
                ch_dmask[c] <= '0;
                ch_cmask[c] <= '0;
            end else if (reg_wr && (reg_addr[REG_AW-1:2] == SEL_W'(c + 1))) begin
                case (reg_addr[1:0])
                    2'd0:    ch_en[c]    <= reg_wdata[0];
                    2'd1:    ch_addr[c]  <= reg_wdata[ADDR_W-1:0];
                    2'd2:    ch_dmask[c] <= reg_wdata;
                    default: ch_cmask[c] <= reg_wdata[CHK_W-1:0];
                endcase
            end
        end
    end

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_AW'(0): reg_rdata = {28'd0, ctrl_q};
            REG_AW'(1): reg_rdata = {30'd0, ue_flag, ce_flag};
            REG_AW'(2): reg_rdata = 32'(ce_addr);
            REG_AW'(3): reg_rdata = 32'(ue_addr);
            default: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (reg_addr[REG_AW-1:2] == SEL_W'(c + 1)) begin
                        case (reg_addr[1:0])
                            2'd0:    reg_rdata = {31'd0, ch_en[c]};
                            2'd1:    reg_rdata = 32'(ch_addr[c]);
                            2'd2:    reg_rdata = ch_dmask[c];
                            default: reg_rdata = 32'(ch_cmask[c]);
                        endcase
                    end
                end
            end
        endcase
    end

    // Encode the write word.
    always_comb begin
        wr_word.data = mem_wdata;
        wr_word.chk  = ecc_gen(mem_wdata);
    end

    ecc_sram_array #(
        .ADDR_W (ADDR_W),
        .WORD_W (CODE_W)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (mem_req),
        .we     (mem_we),
        .addr   (mem_addr),
        .wword  (wr_word),
        .rword  (arr_word),
        .raddr  (arr_addr),
        .rvalid (mem_rvalid)
    );

    ecc_inj_stage #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH)
    ) u_inj (
        .ch_en    (ch_en),
        .ch_addr  (ch_addr),
        .ch_dmask (ch_dmask),
        .ch_cmask (ch_cmask),
        .raddr    (arr_addr),
        .word_in  (arr_word),
        .word_out (inj_word),
        .hit      (inj_hit)
    );

    ecc_secded_dec u_dec (
        .word_in  (inj_word),
        .data_out (mem_rdata),
        .ce       (mem_ce),
        .ue       (mem_ue)
    );

    ecc_err_report #(
        .ADDR_W (ADDR_W)
    ) u_rep (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (mem_rvalid),
        .evt_ce    (mem_ce),
        .evt_ue    (mem_ue),
        .evt_addr  (arr_addr),
        .rep_ce_en (ctrl_q[0]),
        .rep_ue_en (ctrl_q[1]),
        .clr_ce    (clr_ce),
        .clr_ue    (clr_ue),
        .ce_flag   (ce_flag),
        .ue_flag   (ue_flag),
        .ce_addr   (ce_addr),
        .ue_addr   (ue_addr)
    );

    // Level interrupts gated by their enables.
    always_comb begin
        irq_ce = ce_flag && ctrl_q[2];
        irq_ue = ue_flag && ctrl_q[3];
    end
endmodule

// File: rtl/ecc_sram_inj_chk.sv
// Checker for ecc_sram_inj: timing of read responses, exclusivity of
// error indications, flag origin, first-fault address hold and
// interrupt gating. Attached to the top by bind below.
module ecc_sram_inj_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_rvalid,
    input logic              mem_ce,
    input logic              mem_ue,
    input logic              inj_hit,
    input logic              ce_flag,
    input logic              ue_flag,
    input logic              clr_ce,
    input logic [ADDR_W-1:0] ce_addr,
    input logic              irq_ce,
    input logic              irq_ue
);
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> mem_rvalid);                          // R1
    AST_WRITE_NO_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> !mem_rvalid);                          // R1
    AST_CE_UE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_ce && mem_ue));                                          // R2
    AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rvalid && !inj_hit) |-> (!mem_ce && !mem_ue));            // R4
    AST_CE_FLAG_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_flag) |-> $past(mem_rvalid && mem_ce));               // R6
    AST_CE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ce_flag) && ce_flag && !$past(clr_ce)) |-> $stable(ce_addr)); // R7
    AST_IRQ_CE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ce |-> ce_flag);                                           // R9
    AST_IRQ_UE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ue |-> ue_flag);                                           // R9
endmodule

bind ecc_sram_inj ecc_sram_inj_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_rvalid (mem_rvalid),
    .mem_ce     (mem_ce),
    .mem_ue     (mem_ue),
    .inj_hit    (inj_hit),
    .ce_flag    (ce_flag),
    .ue_flag    (ue_flag),
    .clr_ce     (clr_ce),
    .ce_addr    (ce_addr),
    .irq_ce     (irq_ce),
    .irq_ue     (irq_ue)
);

// File: tb/ecc_sram_inj_tb.sv
`timescale 1ns/1ps
module ecc_sram_inj_tb;
    localparam int AW  = 6;
    localparam int RAW = 5;

    typedef struct packed {
        logic [31:0] wdata;
        logic [31:0] dmask;
        logic [6:0]  cmask;
        logic        exp_ce;
        logic        exp_ue;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'hA5A5_1234, 32'h0000_0000, 7'h00, 1'b0, 1'b0},
        '{32'h1357_9BDF, 32'h0000_0001, 7'h00, 1'b1, 1'b0},
        '{32'hFFFF_0000, 32'h8000_0000, 7'h00, 1'b1, 1'b0},
        '{32'h0F0F_F0F0, 32'h0002_0000, 7'h00, 1'b1, 1'b0},
        '{32'hDEAD_BEEF, 32'h0000_0000, 7'h01, 1'b1, 1'b0},
        '{32'h0000_0000, 32'h0000_0000, 7'h40, 1'b1, 1'b0},
        '{32'hCAFE_F00D, 32'h0000_0003, 7'h00, 1'b0, 1'b1},
        '{32'h1234_5678, 32'h0000_0100, 7'h02, 1'b0, 1'b1},
        '{32'h8765_4321, 32'h0000_0000, 7'h03, 1'b0, 1'b1},
        '{32'hFFFF_FFFF, 32'h8000_0001, 7'h00, 1'b0, 1'b1}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mem_req = 1'b0;
    logic           mem_we = 1'b0;
    logic [AW-1:0]  mem_addr = '0;
    logic [31:0]    mem_wdata = '0;
    logic           mem_rvalid;
    logic [31:0]    mem_rdata;
    logic           mem_ce;
    logic           mem_ue;
    logic           reg_valid = 1'b0;
    logic           reg_ready;
    logic           reg_write = 1'b0;
    logic [RAW-1:0] reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           irq_ce;
    logic           irq_ue;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ecc_sram_inj #(.ADDR_W(AW), .NUM_CH(2), .REG_AW(RAW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_ce(mem_ce), .mem_ue(mem_ue),
        .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ce(irq_ce), .irq_ue(irq_ue)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = RAW'(a); reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic reg_rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = RAW'(a);
        #1 d = reg_rdata;
    endtask

    task automatic mem_write(input int a, input logic [31:0] d);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = AW'(a); mem_wdata = d;
        @(negedge clk);
        mem_req = 1'b0; mem_we = 1'b0;
        check("R1 no rvalid on write", {31'd0, mem_rvalid}, 32'd0);
    endtask

    task automatic mem_read(input int a, output logic [31:0] d, output logic ce, output logic ue);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b0; mem_addr = AW'(a);
        @(negedge clk);
        mem_req = 1'b0;
        check("R1 rvalid in data cycle", {31'd0, mem_rvalid}, 32'd1);
        d = mem_rdata; ce = mem_ce; ue = mem_ue;
    endtask

    // channel c register index helper
    function automatic int chr(input int c, input int off);
        return 4 + 4 * c + off;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] d;
        logic ce;
        logic ue;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        reg_rd(0, r);  check("R10 control", r, 0);
        reg_rd(1, r);  check("R10 status", r, 0);
        reg_rd(2, r);  check("R10 ce addr", r, 0);
        reg_rd(chr(0, 0), r); check("R10 ch0 enable", r, 0);
        reg_rd(chr(1, 2), r); check("R10 ch1 dmask", r, 0);
        check("R10 irqs", {30'd0, irq_ue, irq_ce}, 0);

        // Vector table: channel 0 aimed at word 5, reporting off (R2, R3)
        reg_wr(chr(0, 1), 5);
        reg_wr(chr(0, 0), 1);
        for (int i = 0; i < NV; i++) begin
            reg_wr(chr(0, 2), VECS[i].dmask);
            reg_wr(chr(0, 3), 32'(VECS[i].cmask));
            mem_write(5, VECS[i].wdata);
            mem_read(5, d, ce, ue);
            if (VECS[i].exp_ue) begin
                check("R3 raw data", d, VECS[i].wdata ^ VECS[i].dmask);
                check("R3 flags", {30'd0, ue, ce}, 32'd2);
            end else begin
                check("R2 corrected data", d, VECS[i].wdata);
                check("R2 flags", {30'd0, ue, ce}, {31'd0, VECS[i].exp_ce});
            end
        end
        // R8: reporting disabled, status untouched
        reg_rd(1, r); check("R8 status stays clear", r, 0);

        // R5: disable channel, stored word intact
        reg_wr(chr(0, 0), 0);
        mem_read(5, d, ce, ue);
        check("R5 stored data", d, 32'hFFFF_FFFF);
        check("R5 clean flags", {30'd0, ue, ce}, 0);

        // R4: enabled channel, other address untouched
        reg_wr(chr(0, 0), 1);
        reg_wr(chr(0, 2), 32'h0000_0010);
        reg_wr(chr(0, 3), 0);
        mem_write(6, 32'h6666_6666);
        mem_read(6, d, ce, ue);
        check("R4 non-target data", d, 32'h6666_6666);
        check("R4 non-target flags", {30'd0, ue, ce}, 0);

        // R11: two channels on word 7, masks cancel then combine
        reg_wr(chr(0, 1), 7);
        reg_wr(chr(0, 2), 32'h0000_0008);
        reg_wr(chr(1, 1), 7);
        reg_wr(chr(1, 2), 32'h0000_0008);
        reg_wr(chr(1, 0), 1);
        mem_write(7, 32'h7777_0000);
        mem_read(7, d, ce, ue);
        check("R11 cancel data", d, 32'h7777_0000);
        check("R11 cancel flags", {30'd0, ue, ce}, 0);
        reg_wr(chr(1, 2), 32'h0000_0010);
        mem_read(7, d, ce, ue);
        check("R11 combined raw", d, 32'h7777_0018);
        check("R11 combined ue", {30'd0, ue, ce}, 2);
        reg_wr(chr(1, 0), 0);

        // R6, R7, R9: reporting on, interrupts off
        reg_wr(0, 32'h3);
        reg_wr(chr(0, 1), 5);
        reg_wr(chr(0, 2), 32'h0000_0004);
        mem_read(5, d, ce, ue);
        check("R2 corrected again", d, 32'hFFFF_FFFF);
        reg_rd(1, r); check("R6 ce flag set", r, 1);
        reg_rd(2, r); check("R7 first ce addr", r, 5);
        check("R9 irq_ce masked", {31'd0, irq_ce}, 0);
        mem_write(9, 32'h9999_9999);
        reg_wr(chr(0, 1), 9);
        mem_read(9, d, ce, ue);
        reg_rd(2, r); check("R7 ce addr held", r, 5);
        reg_wr(0, 32'h7);
        check("R9 irq_ce on", {31'd0, irq_ce}, 1);
        reg_wr(1, 32'h1);
        reg_rd(1, r); check("R6 W1C clears", r, 0);
        check("R9 irq_ce off", {31'd0, irq_ce}, 0);
        mem_read(9, d, ce, ue);
        reg_rd(2, r); check("R7 new ce addr", r, 9);

        // Uncorrectable reporting, W1C of zero has no effect
        reg_wr(chr(0, 2), 32'h0000_0006);
        mem_read(9, d, ce, ue);
        reg_rd(1, r); check("R6 ue flag set", r, 3);
        reg_rd(3, r); check("R7 ue addr", r, 9);
        check("R9 irq_ue masked", {31'd0, irq_ue}, 0);
        reg_wr(1, 32'h0);
        reg_rd(1, r); check("R6 write zero keeps", r, 3);
        reg_wr(0, 32'hB);
        check("R9 irq_ue on", {31'd0, irq_ue}, 1);
        reg_wr(1, 32'h2);
        reg_rd(1, r); check("R6 W1C ue only", r, 1);

        // R8: ue reporting off, event ignored
        reg_wr(0, 32'h1);
        mem_read(9, d, ce, ue);
        reg_rd(1, r); check("R8 ue ignored", r, 1);

        @(negedge clk);
        check("R1 rvalid drops", {31'd0, mem_rvalid}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule